// File: doc/BRIEF.md
# Codec Link Sleep and Wake Sequencer

This block is the control state machine that takes a serial audio codec link into its low-power state and brings it back out. On a power-down command it first withdraws the enables of both audio channels. It then waits until each channel's transmit path has drained. Next it issues one fixed codec register write that sets the codec's power-down bit. It waits for that write to leave the codec output path, and then it reports the link as asleep. While the link is asleep, and until a wake-up has fully completed, no audio channel is enabled. As a result no playback or capture can start while the codec bit clock is stopped.

A wake-up is always started from the controller side, in one of three ways. A cold wake drives the codec reset line low for a set number of clock cycles. A warm wake drives the frame-sync line high for a set width. A frame-sync wake drives frame sync high as well, but only after a guard of a set number of audio frames. That guard is counted from the frame in which the power-down write was accepted. A frame-sync wake request that arrives earlier is held and is not lost. It fires once the guard expires. After any wake pulse the sequencer waits for the codec-ready indication, returns to normal running and emits a one-cycle completion pulse. A status output always shows the current step.

Top module: `aclink_pwr_seq`

## Requirements
- R1: After reset, state reads 0 (running), codec_rst_n is 1, sync_out is 0, cw_req is 0 and done is 0, and chan_en follows chan_en_req.
- R2: chan_en equals chan_en_req only while state is 0; in every other state both bits of chan_en are 0.
- R3: A pd_req pulse while running moves state to 1 (quiescing) on the next cycle. The state stays 1 until both bits of tx_empty are 1, and then moves to 2 (power-down write).
- R4: In state 2, cw_req is 1 and cw_word is 16'h2680 (codec register 0x26, power-down bit set). cw_req stays high until a cycle with cw_ack high, after which state becomes 3 (draining) and cw_req drops.
- R5: In state 3 the sequencer waits for cw_empty; the cycle after cw_empty is seen, state becomes 4 (asleep).
- R6: A wake_req with wake_mode 2'b00 (cold) while asleep moves state to 5 (waking) on the next cycle. codec_rst_n is then low for exactly COLD_CYC cycles, and sync_out stays 0.
- R7: A wake_req with wake_mode 2'b01 (warm) while asleep drives sync_out high for exactly WARM_CYC cycles starting the next cycle, with codec_rst_n held at 1.
- R8: A wake_req with wake_mode[1] set (frame-sync) is held while asleep until LOCK_FRAMES frame_tick pulses have been counted since the cycle cw_ack was accepted. The move to state 5 occurs the cycle after the counter reaches LOCK_FRAMES, and sync_out is then high for exactly SYNC_CYC cycles.
- R9: After the wake pulse, state is 6 (waiting for ready) until codec_ready is seen. State then returns to 0 and done is 1 for exactly one cycle.
- R10: wake_req outside state 4 and pd_req outside state 0 have no effect on state, codec_rst_n or sync_out.
- R11: Cold and warm wakes are not subject to the frame guard; they start the cycle after the request even if no frame_tick has occurred since power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | 1 | Power-down command pulse |
| wake_req | input | 1 | Wake command pulse |
| wake_mode | input | 2 | Wake method: 00 cold, 01 warm, 1x frame-sync |
| chan_en_req | input | 2 | Software enables for channel A (bit 0) and B (bit 1) |
| tx_empty | input | 2 | Transmit-drained flags for channel A and B |
| cw_ack | input | 1 | Codec write path accepted the request |
| cw_empty | input | 1 | Codec write path has shifted the word out |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| codec_ready | input | 1 | Codec reports it is ready after wake |
| chan_en | output | 2 | Effective channel enables |
| cw_req | output | 1 | Codec register write request |
| cw_word | output | 16 | Codec write word (address high byte, data low byte) |
| codec_rst_n | output | 1 | Codec reset drive, active low |
| sync_out | output | 1 | Frame-sync drive used for wake |
| state | output | 3 | Current sequencer step |
| done | output | 1 | One-cycle pulse on return to running |

## Verification
Every state change lands one clock after the input that causes it. This is because the state, the wake kind and the done flag sit in one register stage, and the outputs decode that register. The bench drives each stimulus at a falling edge and reads the response at the next falling edge. For the frame guard, the counter takes one edge to reach its limit and the state moves one edge later. The bench therefore checks that the state is still asleep one cycle after the final tick and has moved to waking two cycles after it. Pulse widths are counted at falling edges, starting with the first falling edge after the request, and must equal the parameter exactly.

// File: rtl/aclink_pwr_pkg.sv
package aclink_pwr_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_QUIESCE    = 3'd1,
        ST_PD_WRITE   = 3'd2,
        ST_DRAIN      = 3'd3,
        ST_ASLEEP     = 3'd4,
        ST_WAKE       = 3'd5,
        ST_READY_WAIT = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_COLD  = 2'd0,
        WK_WARM  = 2'd1,
        WK_FSYNC = 2'd2
    } wake_kind_e;

    typedef struct packed {
        seq_state_e st;
        wake_kind_e kind;
        logic       pend;
        logic       done;
    } seq_regs_t;

    function automatic wake_kind_e decode_wake(input logic [1:0] m);
        if (m[1])      return WK_FSYNC;
        else if (m[0]) return WK_WARM;
        else           return WK_COLD;
    endfunction

endpackage

// File: rtl/frame_lockout.sv
module frame_lockout #(
    parameter int LOCK_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic open_o
);
    localparam int CW = $clog2(LOCK_FRAMES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_FRAMES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (tick && cnt_q != LIMIT)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LIMIT;
        else        cnt_q <= cnt_d;
    end

    assign open_o = (cnt_q == LIMIT);

    AST_LOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT) else $error("lockout count out of range"); // R8
    AST_LOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !open_o) else $error("lockout open right after restart"); // R8

endmodule

// File: rtl/wake_pulse_timer.sv
module wake_pulse_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] width,
    output logic          active,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = width;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == CW'(1));

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(width)) else $error("timer load lost"); // R7

endmodule

// File: rtl/aclink_pwr_seq.sv
module aclink_pwr_seq
    import aclink_pwr_pkg::*;
#(
    parameter int          LOCK_FRAMES = 4,
    parameter int          COLD_CYC    = 60,
    parameter int          WARM_CYC    = 50,
    parameter int          SYNC_CYC    = 8,
    parameter logic [7:0]  PD_ADDR     = 8'h26,
    parameter logic [7:0]  PD_DATA     = 8'h80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pd_req,
    input  logic        wake_req,
    input  logic [1:0]  wake_mode,
    input  logic [1:0]  chan_en_req,
    input  logic [1:0]  tx_empty,
    input  logic        cw_ack,
    input  logic        cw_empty,
    input  logic        frame_tick,
    input  logic        codec_ready,
    output logic [1:0]  chan_en,
    output logic        cw_req,
    output logic [15:0] cw_word,
    output logic        codec_rst_n,
    output logic        sync_out,
    output logic [2:0]  state,
    output logic        done
);
    localparam int MAX_CW = (COLD_CYC > WARM_CYC) ?
                            ((COLD_CYC > SYNC_CYC) ? COLD_CYC : SYNC_CYC) :
                            ((WARM_CYC > SYNC_CYC) ? WARM_CYC : SYNC_CYC);
    localparam int TW = $clog2(MAX_CW + 1);
    localparam logic [15:0] PD_WORD = {PD_ADDR, PD_DATA};

    seq_regs_t   r_d, r_q;
    wake_kind_e  eff_kind;
    logic        eff_pend;
    logic        tmr_load, tmr_active, tmr_last;
    logic [TW-1:0] tmr_width;
    logic        lock_restart, lock_open;

    frame_lockout #(.LOCK_FRAMES(LOCK_FRAMES)) i_lockout (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (lock_restart),
        .tick    (frame_tick),
        .open_o  (lock_open)
    );

    wake_pulse_timer #(.CW(TW)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .width  (tmr_width),
        .active (tmr_active),
        .last   (tmr_last)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        tmr_load     = 1'b0;
        lock_restart = 1'b0;
        eff_kind     = wake_req ? decode_wake(wake_mode) : r_q.kind;
        eff_pend     = wake_req | r_q.pend;
        unique case (eff_kind)
            WK_COLD: tmr_width = TW'(COLD_CYC);
            WK_WARM: tmr_width = TW'(WARM_CYC);
            default: tmr_width = TW'(SYNC_CYC);
        endcase
        case (r_q.st)
            ST_RUN: begin
                if (pd_req) r_d.st = ST_QUIESCE;
            end
            ST_QUIESCE: begin
                if (&tx_empty) r_d.st = ST_PD_WRITE;
            end
            ST_PD_WRITE: begin
                if (cw_ack) begin
                    r_d.st       = ST_DRAIN;
                    lock_restart = 1'b1;
                end
            end
            ST_DRAIN: begin
                r_d.pend = 1'b0;
                if (cw_empty) r_d.st = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (wake_req) begin
                    r_d.kind = eff_kind;
                    r_d.pend = 1'b1;
                end
                if (eff_pend && (eff_kind != WK_FSYNC || lock_open)) begin
                    r_d.st   = ST_WAKE;
                    r_d.kind = eff_kind;
                    r_d.pend = 1'b0;
                    tmr_load = 1'b1;
                end
            end
            ST_WAKE: begin
                if (tmr_last) r_d.st = ST_READY_WAIT;
            end
            ST_READY_WAIT: begin
                if (codec_ready) begin
                    r_d.st   = ST_RUN;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RUN;
            r_q.kind <= WK_COLD;
            r_q.pend <= 1'b0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign chan_en     = (r_q.st == ST_RUN) ? chan_en_req : 2'b00;
    assign cw_req      = (r_q.st == ST_PD_WRITE);
    assign cw_word     = PD_WORD;
    assign codec_rst_n = !((r_q.st == ST_WAKE) && (r_q.kind == WK_COLD));
    assign sync_out    = (r_q.st == ST_WAKE) && (r_q.kind != WK_COLD);
    assign state       = r_q.st;
    assign done        = r_q.done;

    AST_CW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cw_req && !cw_ack |=> cw_req) else $error("write request dropped"); // R4
    AST_QUIESCE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PD_WRITE && $past(r_q.st) == ST_QUIESCE) |-> $past(&tx_empty))
        else $error("left quiesce before drain"); // R3
    AST_FSYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAKE && $past(r_q.st) == ST_ASLEEP && r_q.kind == WK_FSYNC)
        |-> $past(lock_open)) else $error("frame-sync wake inside guard"); // R8
    AST_WAKE_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAKE) |-> tmr_active) else $error("wake without timer"); // R6
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_q.st == ST_RUN && $past(r_q.st) == ST_READY_WAIT))
        else $error("stray done"); // R9

endmodule

// File: tb/test_aclink_pwr_seq.sv
module test_aclink_pwr_seq;
    localparam int LOCK = 4, COLD = 60, WARM = 50, SYNC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 0, wake_req = 0, cw_ack = 0, cw_empty = 0;
    logic frame_tick = 0, codec_ready = 0;
    logic [1:0] wake_mode = 0, chan_en_req = 2'b11, tx_empty = 0;
    logic [1:0] chan_en;
    logic cw_req, codec_rst_n, sync_out, done;
    logic [15:0] cw_word;
    logic [2:0] state;
    int vecs = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    aclink_pwr_seq #(.LOCK_FRAMES(LOCK), .COLD_CYC(COLD), .WARM_CYC(WARM),
                     .SYNC_CYC(SYNC)) i_aclink_pwr_seq (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req),
        .wake_mode(wake_mode), .chan_en_req(chan_en_req), .tx_empty(tx_empty),
        .cw_ack(cw_ack), .cw_empty(cw_empty), .frame_tick(frame_tick),
        .codec_ready(codec_ready), .chan_en(chan_en), .cw_req(cw_req),
        .cw_word(cw_word), .codec_rst_n(codec_rst_n), .sync_out(sync_out),
        .state(state), .done(done));

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        nclk(1);
        chk("R1 state", state, 0);
        chk("R1 rst_n", codec_rst_n, 1);
        chk("R1 sync", sync_out, 0);
        chk("R1 cw_req", cw_req, 0);
        chk("R1 done", done, 0);
        chk("R1 chan_en", chan_en, 2'b11);
        chan_en_req = 2'b01; nclk(1);
        chk("R2 chan_en follows in run", chan_en, 2'b01);
        chan_en_req = 2'b11;
    endtask

    task automatic t_powerdown();
        tx_empty = 2'b00; cw_empty = 0;
        pd_req = 1; nclk(1); pd_req = 0;
        chk("R3 quiesce entered", state, 1);
        chk("R2 chan off", chan_en, 0);
        tx_empty = 2'b01; nclk(3);
        chk("R3 waits both empty", state, 1);
        chk("R3 no write yet", cw_req, 0);
        tx_empty = 2'b11; nclk(1);
        chk("R3 to write", state, 2);
        chk("R4 cw_req", cw_req, 1);
        chk("R4 cw_word", cw_word, 16'h2680);
        nclk(3);
        chk("R4 held without ack", cw_req, 1);
        cw_ack = 1; nclk(1); cw_ack = 0;
        chk("R4 to drain", state, 3);
        chk("R4 req drops", cw_req, 0);
        nclk(2);
        chk("R5 waits cw_empty", state, 3);
        cw_empty = 1; nclk(1); cw_empty = 0;
        chk("R5 asleep", state, 4);
        chk("R2 chan off asleep", chan_en, 0);
    endtask

    task automatic finish_ready();
        nclk(2);
        chk("R9 waits ready", state, 6);
        chk("R9 no early done", done, 0);
        codec_ready = 1; nclk(1); codec_ready = 0;
        chk("R9 back to run", state, 0);
        chk("R9 done pulse", done, 1);
        nclk(1);
        chk("R9 done one cycle", done, 0);
        chk("R2 chan restored", chan_en, 2'b11);
    endtask

    task automatic t_cold();
        int n = 0;
        t_powerdown();
        wake_mode = 2'b00; wake_req = 1; nclk(1); wake_req = 0;
        chk("R11 cold no guard", state, 5);
        chk("R6 sync low", sync_out, 0);
        while (!codec_rst_n && n < 1000) begin n++; nclk(1); end
        chk("R6 cold width", n, COLD);
        finish_ready();
    endtask

    task automatic t_warm();
        int n = 0;
        t_powerdown();
        wake_mode = 2'b01; wake_req = 1; nclk(1); wake_req = 0;
        chk("R11 warm no guard", state, 5);
        while (sync_out && n < 1000) begin
            if (!codec_rst_n) chk("R7 rst held high", 0, 1);
            n++; nclk(1);
        end
        chk("R7 warm width", n, WARM);
        finish_ready();
    endtask

    task automatic t_fsync();
        int n = 0;
        t_powerdown();
        wake_mode = 2'b10; wake_req = 1; nclk(1); wake_req = 0;
        nclk(10);
        chk("R8 held early", state, 4);
        chk("R8 no sync early", sync_out, 0);
        for (int k = 0; k < LOCK - 1; k++) begin
            frame_tick = 1; nclk(1); frame_tick = 0; nclk(2);
        end
        chk("R8 still held", state, 4);
        frame_tick = 1; nclk(1); frame_tick = 0;
        chk("R8 not yet at count", state, 4);
        nclk(1);
        chk("R8 wake after count", state, 5);
        while (sync_out && n < 1000) begin n++; nclk(1); end
        chk("R8 sync width", n, SYNC);
        finish_ready();
    endtask

    task automatic t_ignore();
        wake_mode = 2'b00; wake_req = 1; nclk(1); wake_req = 0;
        chk("R10 wake in run state", state, 0);
        chk("R10 wake in run rst", codec_rst_n, 1);
        chk("R10 wake in run sync", sync_out, 0);
        t_powerdown();
        pd_req = 1; nclk(1); pd_req = 0; nclk(1);
        chk("R10 pd while asleep", state, 4);
        wake_mode = 2'b01; wake_req = 1; nclk(1); wake_req = 0;
        chk("R10 wake from asleep ok", state, 5);
        wake_mode = 2'b00; wake_req = 1; nclk(1); wake_req = 0;
        chk("R10 wake in wake no cold", codec_rst_n, 1);
        while (state == 5) nclk(1);
        finish_ready();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_cold();
        t_warm();
        t_fsync();
        t_ignore();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vecs++; fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule